// File: doc/BRIEF.md
# SPI Receive Status and Overrun Logic

This block holds the status and interrupt logic that sits between a serial shift engine and a register bus. Each time the shift engine finishes a frame, it presents a strobe and a 16-bit word. The block keeps the last accepted word in a receive data register. It also maintains four flags: receive-not-empty, transmit-empty, overrun and underrun.

When a frame arrives before software has read the previous word, the block enters overrun. In overrun it drops that frame and every later one, and the stored word is kept. Software leaves overrun with two reads in a fixed order: first the data register, then the status register. The flags are combined with three enable bits. Overrun and underrun share one error enable. The result is one request per event and a single merged interrupt line.

The register bus drives one-cycle strobes:
- a data-register read,
- a status-register read,
- a data-register write.

The shift engine drives three event strobes:
- frame complete,
- transmit-word load,
- underrun.

Top module: `spi_rx_status`

## Requirements
- R1: After reset, `rx_data_o` is 0 and `rxne_o`, `txe_o`, `ovr_o`, `udr_o` and all interrupt outputs are 0.
- R2: A frame is accepted when three conditions hold: `frame_done_i` is 1, `ovr_o` is 0, and either `rxne_o` is 0 or `dr_rd_i` is 1 in the same cycle. On the next cycle `rx_data_o` equals `frame_data_i` and `rxne_o` is 1.
- R3: `dr_rd_i` clears `rxne_o` on the next cycle unless a frame is accepted in the same cycle. `rx_data_o` always shows the last accepted word, so a data read during overrun returns the last good word.
- R4: A frame that arrives while `ovr_o` is 0, `rxne_o` is 1 and `dr_rd_i` is 0 sets `ovr_o` on the next cycle, and `rx_data_o` keeps the old word.
- R5: While `ovr_o` is 1, every arriving frame is discarded and `rx_data_o` does not change.
- R6: While `ovr_o` is 1, a `sr_rd_i` pulse clears `ovr_o` on the next cycle only if at least one `dr_rd_i` pulse has occurred since the flag was set. A status read without that earlier data read leaves the flag set, and so does a data read alone.
- R7: If a frame arrives in the same cycle as the status read that would clear overrun, `ovr_o` stays 1 and the word is discarded. Clearing then needs a new data read followed by a status read.
- R8: `tx_load_i` sets `txe_o` on the next cycle. `dr_wr_i` clears it. When both occur in the same cycle, the set wins.
- R9: `underrun_i` sets `udr_o`. A `sr_rd_i` without `underrun_i` in the same cycle clears it on the next cycle.
- R10: The per-event requests are combinational:
  - `irq_txe_o` = `txe_o & en_txe_i`
  - `irq_rxne_o` = `rxne_o & en_rxne_i`
  - `irq_err_o` = `(ovr_o | udr_o) & en_err_i`
- R11: `irq_o` is the OR of `irq_txe_o`, `irq_rxne_o` and `irq_err_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| frame_done_i | input | 1 | Shift engine finished a frame |
| frame_data_i | input | 16 | Word of the finished frame |
| tx_load_i | input | 1 | Shift engine took the transmit word |
| underrun_i | input | 1 | Underrun event |
| dr_rd_i | input | 1 | Data register read strobe |
| sr_rd_i | input | 1 | Status register read strobe |
| dr_wr_i | input | 1 | Data register write strobe |
| en_txe_i | input | 1 | Transmit-empty interrupt enable |
| en_rxne_i | input | 1 | Receive-not-empty interrupt enable |
| en_err_i | input | 1 | Error interrupt enable (overrun and underrun) |
| rx_data_o | output | 16 | Stored receive word |
| rxne_o | output | 1 | Receive-not-empty flag |
| txe_o | output | 1 | Transmit-empty flag |
| ovr_o | output | 1 | Overrun flag |
| udr_o | output | 1 | Underrun flag |
| irq_txe_o | output | 1 | Transmit-empty request |
| irq_rxne_o | output | 1 | Receive-not-empty request |
| irq_err_o | output | 1 | Error request |
| irq_o | output | 1 | Merged interrupt request |

## Verification
On every cycle, the assertions check four things:
- the frozen data word during overrun,
- the entry into overrun,
- that a status read right after overrun begins cannot clear it,
- the set and clear rules of the transmit-empty and receive flags, together with the gating of the requests.

The full two-step clear needs directed scenarios. These cover the wrong order, a missing data read, and a frame colliding with the clearing read. A long random run then compares every output against the bench's reference model.

// File: rtl/spi_rx_status_pkg.sv
package spi_rx_status_pkg;
  typedef struct packed {
    logic txe;
    logic rxne;
    logic ovr;
    logic udr;
  } flags_t;

  typedef struct packed {
    logic txe;
    logic rxne;
    logic err;
  } irq_vec_t;
endpackage

// File: rtl/spi_rx_hold.sv
module spi_rx_hold #(
  parameter int DATA_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              frame_done_i,
  input  logic [DATA_W-1:0] frame_data_i,
  input  logic              dr_rd_i,
  input  logic              sr_rd_i,
  output logic [DATA_W-1:0] data_o,
  output logic              rxne_o,
  output logic              ovr_o
);
  logic [DATA_W-1:0] data_q;
  logic rxne_q, ovr_q, armed_q;
  logic clr_req, collide;

  // second step of the clear sequence, valid only once armed by a data read
  assign clr_req = ovr_q & armed_q & sr_rd_i;
  assign collide = frame_done_i & rxne_q & ~dr_rd_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_q  <= '0;
      rxne_q  <= 1'b0;
      ovr_q   <= 1'b0;
      armed_q <= 1'b0;
    end else if (ovr_q) begin
      if (clr_req) begin
        // a colliding frame re-raises overrun: stay set, disarm
        if (!frame_done_i) ovr_q <= 1'b0;
        armed_q <= 1'b0;
      end else if (dr_rd_i) begin
        armed_q <= 1'b1;
      end
      if (dr_rd_i) rxne_q <= 1'b0;
    end else if (collide) begin
      ovr_q   <= 1'b1;
      armed_q <= 1'b0;
    end else if (frame_done_i) begin
      data_q <= frame_data_i;
      rxne_q <= 1'b1;
    end else if (dr_rd_i) begin
      rxne_q <= 1'b0;
    end
  end

  assign data_o = data_q;
  assign rxne_o = rxne_q;
  assign ovr_o  = ovr_q;
endmodule

// File: rtl/spi_tx_flags.sv
module spi_tx_flags (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tx_load_i,
  input  logic dr_wr_i,
  input  logic underrun_i,
  input  logic sr_rd_i,
  output logic txe_o,
  output logic udr_o
);
  logic txe_q, udr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      txe_q <= 1'b0;
      udr_q <= 1'b0;
    end else begin
      if (tx_load_i)    txe_q <= 1'b1;
      else if (dr_wr_i) txe_q <= 1'b0;
      if (underrun_i)   udr_q <= 1'b1;
      else if (sr_rd_i) udr_q <= 1'b0;
    end
  end

  assign txe_o = txe_q;
  assign udr_o = udr_q;
endmodule

// File: rtl/spi_irq_merge.sv
module spi_irq_merge
  import spi_rx_status_pkg::*;
(
  input  flags_t   flags_i,
  input  logic     en_txe_i,
  input  logic     en_rxne_i,
  input  logic     en_err_i,
  output irq_vec_t req_o,
  output logic     irq_o
);
  always_comb begin
    req_o.txe  = flags_i.txe & en_txe_i;
    req_o.rxne = flags_i.rxne & en_rxne_i;
    req_o.err  = (flags_i.ovr | flags_i.udr) & en_err_i;
  end
  assign irq_o = |req_o;
endmodule

// File: rtl/spi_rx_status.sv
module spi_rx_status
  import spi_rx_status_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              frame_done_i,
  input  logic [DATA_W-1:0] frame_data_i,
  input  logic              tx_load_i,
  input  logic              underrun_i,
  input  logic              dr_rd_i,
  input  logic              sr_rd_i,
  input  logic              dr_wr_i,
  input  logic              en_txe_i,
  input  logic              en_rxne_i,
  input  logic              en_err_i,
  output logic [DATA_W-1:0] rx_data_o,
  output logic              rxne_o,
  output logic              txe_o,
  output logic              ovr_o,
  output logic              udr_o,
  output logic              irq_txe_o,
  output logic              irq_rxne_o,
  output logic              irq_err_o,
  output logic              irq_o
);
  flags_t   flags;
  irq_vec_t req;

  spi_rx_hold #(.DATA_W(DATA_W)) u_rx (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .frame_done_i (frame_done_i),
    .frame_data_i (frame_data_i),
    .dr_rd_i      (dr_rd_i),
    .sr_rd_i      (sr_rd_i),
    .data_o       (rx_data_o),
    .rxne_o       (flags.rxne),
    .ovr_o        (flags.ovr)
  );

  spi_tx_flags u_tx (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .tx_load_i  (tx_load_i),
    .dr_wr_i    (dr_wr_i),
    .underrun_i (underrun_i),
    .sr_rd_i    (sr_rd_i),
    .txe_o      (flags.txe),
    .udr_o      (flags.udr)
  );

  spi_irq_merge u_irq (
    .flags_i   (flags),
    .en_txe_i  (en_txe_i),
    .en_rxne_i (en_rxne_i),
    .en_err_i  (en_err_i),
    .req_o     (req),
    .irq_o     (irq_o)
  );

  assign rxne_o     = flags.rxne;
  assign txe_o      = flags.txe;
  assign ovr_o      = flags.ovr;
  assign udr_o      = flags.udr;
  assign irq_txe_o  = req.txe;
  assign irq_rxne_o = req.rxne;
  assign irq_err_o  = req.err;
endmodule

// File: rtl/spi_rx_status_chk.sv
module spi_rx_status_chk #(
  parameter int DATA_W = 16
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              frame_done_i,
  input logic [DATA_W-1:0] frame_data_i,
  input logic              tx_load_i,
  input logic              dr_rd_i,
  input logic              sr_rd_i,
  input logic              dr_wr_i,
  input logic              en_err_i,
  input logic [DATA_W-1:0] rx_data_o,
  input logic              rxne_o,
  input logic              txe_o,
  input logic              ovr_o,
  input logic              irq_rxne_o,
  input logic              irq_err_o,
  input logic              irq_o
);
  assert_accept_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ovr_o && frame_done_i && (!rxne_o || dr_rd_i)) |=> (rxne_o && rx_data_o == $past(frame_data_i)));

  assert_rd_clears_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dr_rd_i && !frame_done_i) |=> !rxne_o);

  assert_ovr_entry_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ovr_o && frame_done_i && rxne_o && !dr_rd_i) |=> (ovr_o && $stable(rx_data_o)));

  assert_frozen_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovr_o |=> $stable(rx_data_o));

  assert_no_early_clear_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(ovr_o) && sr_rd_i) |=> ovr_o);

  assert_txe_set_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_load_i |=> txe_o);

  assert_txe_clr_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dr_wr_i && !tx_load_i) |=> !txe_o);

  assert_gate_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((!rxne_o |-> !irq_rxne_o) and (!en_err_i |-> !irq_err_o)));

  assert_merge_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_rxne_o || irq_err_o) |-> irq_o);
endmodule

bind spi_rx_status spi_rx_status_chk #(.DATA_W(DATA_W)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .frame_done_i (frame_done_i),
  .frame_data_i (frame_data_i),
  .tx_load_i    (tx_load_i),
  .dr_rd_i      (dr_rd_i),
  .sr_rd_i      (sr_rd_i),
  .dr_wr_i      (dr_wr_i),
  .en_err_i     (en_err_i),
  .rx_data_o    (rx_data_o),
  .rxne_o       (rxne_o),
  .txe_o        (txe_o),
  .ovr_o        (ovr_o),
  .irq_rxne_o   (irq_rxne_o),
  .irq_err_o    (irq_err_o),
  .irq_o        (irq_o)
);

// File: tb/spi_rx_status_tb.sv
module spi_rx_status_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic fd = 0, tl = 0, ur = 0, drr = 0, srr = 0, drw = 0;
  logic e_txe = 0, e_rxne = 0, e_err = 0;
  logic [15:0] fdata = '0;
  logic [15:0] rx_data;
  logic rxne, txe, ovr, udr, i_txe, i_rxne, i_err, irq;

  spi_rx_status u_dut (
    .clk_i(clk), .rst_ni(rst_n), .frame_done_i(fd), .frame_data_i(fdata),
    .tx_load_i(tl), .underrun_i(ur), .dr_rd_i(drr), .sr_rd_i(srr), .dr_wr_i(drw),
    .en_txe_i(e_txe), .en_rxne_i(e_rxne), .en_err_i(e_err),
    .rx_data_o(rx_data), .rxne_o(rxne), .txe_o(txe), .ovr_o(ovr), .udr_o(udr),
    .irq_txe_o(i_txe), .irq_rxne_o(i_rxne), .irq_err_o(i_err), .irq_o(irq)
  );

  int checks = 0, errors = 0;
  bit done = 0;

  // reference model state
  logic [15:0] m_data = '0;
  bit m_rxne = 0, m_ovr = 0, m_arm = 0, m_txe = 0, m_udr = 0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic model_step();
    if (m_ovr) begin
      if (srr && m_arm) begin
        if (!fd) m_ovr = 0;
        m_arm = 0;
      end else if (drr) m_arm = 1;
      if (drr) m_rxne = 0;
    end else if (fd && m_rxne && !drr) begin
      m_ovr = 1;
      m_arm = 0;
    end else if (fd) begin
      m_data = fdata;
      m_rxne = 1;
    end else if (drr) m_rxne = 0;
    if (tl) m_txe = 1; else if (drw) m_txe = 0;
    if (ur) m_udr = 1; else if (srr) m_udr = 0;
  endtask

  task automatic compare_all();
    bit ei, ri, xi;
    chk("R2/R3 rx_data", rx_data, m_data);
    chk("R2/R3 rxne", rxne, m_rxne);
    chk("R4/R6 ovr", ovr, m_ovr);
    chk("R8 txe", txe, m_txe);
    chk("R9 udr", udr, m_udr);
    xi = m_txe && e_txe;
    ri = m_rxne && e_rxne;
    ei = (m_ovr || m_udr) && e_err;
    chk("R10 irq_txe", i_txe, xi);
    chk("R10 irq_rxne", i_rxne, ri);
    chk("R10 irq_err", i_err, ei);
    chk("R11 irq", irq, xi || ri || ei);
  endtask

  // apply current strobes for one cycle, then compare at the falling edge
  task automatic tick();
    @(posedge clk);
    model_step();
    @(negedge clk);
    compare_all();
    fd = 0; tl = 0; ur = 0; drr = 0; srr = 0; drw = 0;
  endtask

  task automatic frame(input logic [15:0] d);
    fd = 1; fdata = d; tick();
  endtask

  initial begin
    #2000000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    @(negedge clk); @(negedge clk);
    // R1 reset values
    chk("R1 rx_data", rx_data, 0);
    chk("R1 flags", {rxne, txe, ovr, udr}, 0);
    chk("R1 irq", {i_txe, i_rxne, i_err, irq}, 0);
    rst_n = 1;
    e_txe = 1; e_rxne = 1; e_err = 1;
    @(negedge clk);

    frame(16'hA1A1);
    chk("R2 accept", {rxne, rx_data}, {1'b1, 16'hA1A1});
    frame(16'hB2B2);
    chk("R4 overrun set, old word kept", {ovr, rx_data}, {1'b1, 16'hA1A1});
    frame(16'hC3C3);
    chk("R5 discarded", rx_data, 16'hA1A1);
    srr = 1; tick();
    chk("R6 status read first does not clear", ovr, 1);
    drr = 1; tick();
    chk("R3 read in overrun returns last good word", {rx_data, rxne, ovr}, {16'hA1A1, 1'b0, 1'b1});
    frame(16'hD4D4);
    chk("R5 still discarded after read", {rx_data, rxne}, {16'hA1A1, 1'b0});
    srr = 1; tick();
    chk("R6 cleared by data then status read", ovr, 0);
    frame(16'hE5E5);
    chk("R2 accepted after clear", rx_data, 16'hE5E5);

    // R7: frame coinciding with the clearing status read
    frame(16'h1111);
    drr = 1; tick();
    srr = 1; fd = 1; fdata = 16'h2222; tick();
    chk("R7 collision keeps overrun", {ovr, rx_data}, {1'b1, 16'hE5E5});
    srr = 1; tick();
    chk("R7 needs a new data read", ovr, 1);
    drr = 1; tick();
    srr = 1; tick();
    chk("R7 clears after new sequence", ovr, 0);

    // R2/R3 read and frame in same cycle while full
    frame(16'h3333);
    drr = 1; fd = 1; fdata = 16'h4444; tick();
    chk("R2 read plus frame accepted", {ovr, rxne, rx_data}, {1'b0, 1'b1, 16'h4444});
    drr = 1; tick();
    chk("R3 read clears rxne", rxne, 0);

    // R8 / R9
    tl = 1; tick();
    chk("R8 load sets txe", txe, 1);
    drw = 1; tick();
    chk("R8 write clears txe", txe, 0);
    tl = 1; drw = 1; tick();
    chk("R8 load wins", txe, 1);
    ur = 1; tick();
    chk("R9 udr set", {udr, i_err}, 2'b11);
    ur = 1; srr = 1; tick();
    chk("R9 event beats clear", udr, 1);
    srr = 1; tick();
    chk("R9 status read clears", udr, 0);

    // R10/R11 enable gating
    e_txe = 0; e_rxne = 0; e_err = 0;
    @(negedge clk);
    compare_all();
    chk("R11 all disabled", irq, 0);

    // random phase, compared every cycle
    for (int i = 0; i < 4000; i++) begin
      fd = ($urandom % 3) == 0;
      fdata = 16'($urandom);
      drr = ($urandom % 4) == 0;
      srr = ($urandom % 4) == 0;
      tl = ($urandom % 6) == 0;
      drw = ($urandom % 5) == 0;
      ur = ($urandom % 20) == 0;
      e_txe = 1'($urandom); e_rxne = 1'($urandom); e_err = 1'($urandom);
      tick();
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule